// File: doc/BRIEF.md
# Video Line and Frame Timing Sequencer

This block runs from a fast system clock and produces the scanline and frame cadence of a video timing generator. The system clock is not a whole multiple of the line rate, so the length of each line in clock cycles comes from a fixed-point accumulator. A constant step is added to the accumulator once per line. The integer part of the sum is that line's length, and the fractional part is kept for the next line. Over a long run the average line length then matches the true ratio, and no line differs from another by more than one cycle.

On top of the line cadence the block keeps the current line number and the frame count. It raises a one-cycle vertical-blank interrupt when the scan reaches a fixed line and holds a blanking level until the frame wraps. It also drives a field bit for interlaced output, a one-cycle line tick for timers, and a periodic audio-update tick. A select input chooses between the 60 Hz standard (263 lines per frame) and the 50 Hz standard (313 lines per frame). A change of that input is only taken up at the next frame boundary. With the default steps of 8791293 and 8864320 in 20.12 format, lines average about 2146.31 and 2164.14 cycles respectively.

The control is a small state machine with three states. `S_INIT` lasts one cycle after reset; it latches the standard and loads the first line length. `S_ACTIVE` covers the visible lines. `S_VBLANK` covers the lines from the blanking line to the end of the frame. The transitions are:
- `S_INIT` to `S_ACTIVE`: unconditional.
- `S_ACTIVE` to `S_VBLANK`: at the end of the line just before the blanking line.
- `S_VBLANK` to `S_ACTIVE`: at the frame wrap.

Top module: `vid_timing_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output reads zero: line, frame, field, the three pulses, the blanking level and the active-standard flag. Reset also clears the fractional accumulator.
- R2: Each line lasts floor((f + S) / 2^FRAC_W) cycles. Here S is the step of the standard in force and f is the fractional remainder left by the previous line (zero after reset). The new remainder is (f + S) mod 2^FRAC_W. `hsync_o` is high for exactly one cycle after the last cycle of each line. The first line starts one cycle after reset is released.
- R3: `line_o` increments in the same cycle that `hsync_o` is high. It goes from total−1 back to 0, where total is 263 for the 60 Hz standard and 313 for the 50 Hz standard.
- R4: `vblank_irq_o` is high for one cycle, together with `hsync_o`, when `line_o` becomes VBL_LINE (240 by default). `vblank_o` is high exactly while `line_o` is at least VBL_LINE.
- R5: `frame_o` increments by one, modulo 2^FRAME_W, at each line wrap and at no other time.
- R6: `audio_tick_o` is high together with every AUDIO_LINES-th `hsync_o` pulse (32 by default), counted from reset. Its line count restarts after each tick and does not depend on frame wraps.
- R7: At each frame wrap, `field_o` takes bit 0 of the new frame count if `interlace_en_i` is 1, and is cleared if it is 0. Between wraps it does not change.
- R8: `pal_sel_i` (1 = 50 Hz) is sampled only in `S_INIT` and at a frame wrap. The sampled value appears on `pal_active_o` and sets both the frame length and the per-line step of the frame that follows. Changing `pal_sel_i` in the middle of a frame has no effect on that frame.
- R9: A reset in the middle of a run restarts the sequence from scratch. The first line after release has length floor(S / 2^FRAC_W), with no remainder carried over from before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_sel_i | input | 1 | Requested standard: 1 = 50 Hz, 0 = 60 Hz |
| interlace_en_i | input | 1 | Enables field toggling at frame wrap |
| hsync_o | output | 1 | One-cycle pulse at the end of each line |
| audio_tick_o | output | 1 | One-cycle pulse every AUDIO_LINES lines |
| vblank_irq_o | output | 1 | One-cycle pulse when the blanking line is reached |
| vblank_o | output | 1 | High during the blanking lines |
| line_o | output | LINE_W | Current line number |
| frame_o | output | FRAME_W | Frame count |
| field_o | output | 1 | Interlace field bit |
| pal_active_o | output | 1 | Standard in force for the current frame |

## Verification
The bound checker watches the local rules on every cycle:
- `hsync_o` is never high two cycles running.
- The line number only steps by one, or to zero, on an `hsync_o` pulse, and stays below the frame length of the standard in force.
- The interrupt, the audio tick and the blanking level agree with the line number.
- The frame count, the field bit and the active standard change only at a wrap.

What these rules cannot show is whether the cycle count of each line follows the fractional carry. The same holds for where exactly in time the audio tick, the field value and the standard switch fall. The bench's reference model establishes these by tracking the accumulator arithmetically across long runs. Those runs include mid-frame changes of the standard, interlace switching and a reset during operation.

// File: rtl/vts_pkg.sv
package vts_pkg;

    typedef enum logic [1:0] {
        S_INIT    = 2'd0,
        S_ACTIVE  = 2'd1,
        S_VBLANK  = 2'd2
    } vts_state_e;

endpackage

// File: rtl/vts_frac_acc.sv
module vts_frac_acc #(
    parameter int ACC_W = 32,
    parameter int FRAC_W = 12,
    parameter logic [ACC_W-1:0] NTSC_STEP = 32'd8791293,
    parameter logic [ACC_W-1:0] PAL_STEP  = 32'd8864320,
    localparam int LEN_W = ACC_W - FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             pal_i,
    output logic [LEN_W-1:0] len_o
);

    logic [FRAC_W-1:0] frac_q;
    logic [ACC_W-1:0]  sum;

    // integer part sizes the next line, fractional part carries forward
    always_comb begin
        sum   = ACC_W'(frac_q) + (pal_i ? PAL_STEP : NTSC_STEP);
        len_o = sum[ACC_W-1:FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_q <= '0;
        end else if (load_i) begin
            frac_q <= sum[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/vts_cycle_ctr.sv
module vts_cycle_ctr #(
    parameter int LEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             end_o
);

    logic [LEN_W-1:0] cnt_q;

    assign end_o = run_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - 1'b1;
        end else if (run_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/vts_line_track.sv
module vts_line_track #(
    parameter int NTSC_LINES  = 263,
    parameter int PAL_LINES   = 313,
    parameter int AUDIO_LINES = 32,
    parameter int FRAME_W     = 16,
    parameter int LINE_W      = 9,
    localparam int AUD_W      = (AUDIO_LINES > 1) ? $clog2(AUDIO_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               pal_i,
    output logic [LINE_W-1:0]  line_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               wrap_o,
    output logic               aud_due_o
);

    localparam logic [LINE_W-1:0] NTSC_LAST = LINE_W'(NTSC_LINES - 1);
    localparam logic [LINE_W-1:0] PAL_LAST  = LINE_W'(PAL_LINES - 1);

    logic [LINE_W-1:0]  line_q;
    logic [FRAME_W-1:0] frame_q;
    logic               at_last;

    assign at_last = (line_q == (pal_i ? PAL_LAST : NTSC_LAST));
    assign wrap_o  = step_i && at_last;
    assign line_o  = line_q;
    assign frame_o = frame_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            frame_q <= '0;
        end else if (step_i) begin
            if (at_last) begin
                line_q  <= '0;
                frame_q <= frame_q + 1'b1;
            end else begin
                line_q  <= line_q + 1'b1;
            end
        end
    end

    generate
        if (AUDIO_LINES > 1) begin : g_aud_cnt
            logic [AUD_W-1:0] aud_q;
            assign aud_due_o = step_i && (aud_q == AUD_W'(AUDIO_LINES - 1));
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    aud_q <= '0;
                end else if (step_i) begin
                    aud_q <= aud_due_o ? '0 : aud_q + 1'b1;
                end
            end
        end else begin : g_aud_every
            assign aud_due_o = step_i;
        end
    endgenerate

endmodule

// File: rtl/vid_timing_seq.sv
module vid_timing_seq
    import vts_pkg::*;
#(
    parameter int ACC_W       = 32,
    parameter int FRAC_W      = 12,
    parameter logic [ACC_W-1:0] NTSC_STEP = 32'd8791293,
    parameter logic [ACC_W-1:0] PAL_STEP  = 32'd8864320,
    parameter int NTSC_LINES  = 263,
    parameter int PAL_LINES   = 313,
    parameter int VBL_LINE    = 240,
    parameter int AUDIO_LINES = 32,
    parameter int FRAME_W     = 16,
    localparam int MAX_LINES  = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES,
    localparam int LINE_W     = $clog2(MAX_LINES),
    localparam int LEN_W      = ACC_W - FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pal_sel_i,
    input  logic               interlace_en_i,
    output logic               hsync_o,
    output logic               audio_tick_o,
    output logic               vblank_irq_o,
    output logic               vblank_o,
    output logic [LINE_W-1:0]  line_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               field_o,
    output logic               pal_active_o
);

    localparam logic [LINE_W-1:0] VBL_PREV = LINE_W'(VBL_LINE - 1);

    vts_state_e         state_q, state_d;
    logic               std_q;
    logic               in_init;
    logic               line_end;
    logic               wrap;
    logic               aud_due;
    logic               load;
    logic               step_sel;
    logic               hit_vbl;
    logic [LEN_W-1:0]   len_next;
    logic [LINE_W-1:0]  line_cur;
    logic [FRAME_W-1:0] frame_cur;

    logic hsync_q, audio_q, irq_q, field_q;

    assign in_init  = (state_q == S_INIT);
    assign load     = in_init || line_end;
    assign step_sel = (in_init || wrap) ? pal_sel_i : std_q;
    assign hit_vbl  = line_end && (line_cur == VBL_PREV);

    vts_frac_acc #(
        .ACC_W    (ACC_W),
        .FRAC_W   (FRAC_W),
        .NTSC_STEP(NTSC_STEP),
        .PAL_STEP (PAL_STEP)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .pal_i (step_sel),
        .len_o (len_next)
    );

    vts_cycle_ctr #(
        .LEN_W(LEN_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (!in_init),
        .load_i(load),
        .len_i (len_next),
        .end_o (line_end)
    );

    vts_line_track #(
        .NTSC_LINES (NTSC_LINES),
        .PAL_LINES  (PAL_LINES),
        .AUDIO_LINES(AUDIO_LINES),
        .FRAME_W    (FRAME_W),
        .LINE_W     (LINE_W)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (line_end),
        .pal_i    (std_q),
        .line_o   (line_cur),
        .frame_o  (frame_cur),
        .wrap_o   (wrap),
        .aud_due_o(aud_due)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_INIT:   state_d = S_ACTIVE;
            S_ACTIVE: if (hit_vbl) state_d = S_VBLANK;
            S_VBLANK: if (wrap)    state_d = S_ACTIVE;
            default:  state_d = S_INIT;
        endcase
    end

    // state register and latched standard
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_INIT;
            std_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (in_init || wrap) begin
                std_q <= pal_sel_i;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_q <= 1'b0;
            audio_q <= 1'b0;
            irq_q   <= 1'b0;
            field_q <= 1'b0;
        end else begin
            hsync_q <= line_end;
            audio_q <= aud_due;
            irq_q   <= hit_vbl;
            if (wrap) begin
                field_q <= interlace_en_i & ~frame_cur[0];
            end
        end
    end

    assign hsync_o      = hsync_q;
    assign audio_tick_o = audio_q;
    assign vblank_irq_o = irq_q;
    assign vblank_o     = (state_q == S_VBLANK);
    assign line_o       = line_cur;
    assign frame_o      = frame_cur;
    assign field_o      = field_q;
    assign pal_active_o = std_q;

endmodule

// File: rtl/vts_chk.sv
module vts_chk #(
    parameter int NTSC_LINES = 263,
    parameter int PAL_LINES  = 313,
    parameter int VBL_LINE   = 240,
    parameter int FRAME_W    = 16,
    parameter int LINE_W     = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hsync_o,
    input logic               audio_tick_o,
    input logic               vblank_irq_o,
    input logic               vblank_o,
    input logic [LINE_W-1:0]  line_o,
    input logic [FRAME_W-1:0] frame_o,
    input logic               field_o,
    input logic               pal_active_o
);

    // R2
    hsync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_o |=> !hsync_o);

    // R3
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_o |-> $stable(line_o));

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_o |-> (line_o == '0 || line_o == $past(line_o) + 1'b1));

    // R3
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(line_o) < (pal_active_o ? PAL_LINES : NTSC_LINES));

    // R4
    irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq_o |-> (hsync_o && int'(line_o) == VBL_LINE));

    // R4
    vblank_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_o == (int'(line_o) >= VBL_LINE));

    // R5
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_o) |-> (hsync_o && line_o == '0));

    // R6
    audio_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        audio_tick_o |-> hsync_o);

    // R7
    field_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_o) |-> (hsync_o && line_o == '0));

    // R8
    std_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pal_active_o) |-> (line_o == '0));

endmodule

bind vid_timing_seq vts_chk #(
    .NTSC_LINES(NTSC_LINES),
    .PAL_LINES (PAL_LINES),
    .VBL_LINE  (VBL_LINE),
    .FRAME_W   (FRAME_W),
    .LINE_W    (LINE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_o     (hsync_o),
    .audio_tick_o(audio_tick_o),
    .vblank_irq_o(vblank_irq_o),
    .vblank_o    (vblank_o),
    .line_o      (line_o),
    .frame_o     (frame_o),
    .field_o     (field_o),
    .pal_active_o(pal_active_o)
);

// File: tb/sim_vid_timing_seq.sv
module sim_vid_timing_seq;

    localparam int ACC_W  = 16;
    localparam int FRAC_W = 4;
    localparam int NSTEP  = 133;   // 8.3125 cycles per line
    localparam int PSTEP  = 171;   // 10.6875 cycles per line
    localparam int NL     = 7;
    localparam int PL     = 9;
    localparam int VBL    = 5;
    localparam int AUDL   = 4;
    localparam int FW     = 4;
    localparam int LW     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pal_sel = 1'b0;
    logic ilace = 1'b0;
    logic hsync, atick, virq, vbl, field, pact;
    logic [LW-1:0] line;
    logic [FW-1:0] frame;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_n, m_next, m_line, m_frame, m_field, m_std, m_frac, m_aud;
    int m_hs, m_at, m_irq;
    int first_hs;

    always #2 clk = ~clk;

    vid_timing_seq #(
        .ACC_W      (ACC_W),
        .FRAC_W     (FRAC_W),
        .NTSC_STEP  (16'(NSTEP)),
        .PAL_STEP   (16'(PSTEP)),
        .NTSC_LINES (NL),
        .PAL_LINES  (PL),
        .VBL_LINE   (VBL),
        .AUDIO_LINES(AUDL),
        .FRAME_W    (FW)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pal_sel_i     (pal_sel),
        .interlace_en_i(ilace),
        .hsync_o       (hsync),
        .audio_tick_o  (atick),
        .vblank_irq_o  (virq),
        .vblank_o      (vbl),
        .line_o        (line),
        .frame_o       (frame),
        .field_o       (field),
        .pal_active_o  (pact)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at model edge %0d: actual=%0d expected=%0d", req, m_n, act, exp);
        end
    endtask

    function automatic int next_len(input int sel);
        int s;
        s = m_frac + (sel != 0 ? PSTEP : NSTEP);
        m_frac = s % (1 << FRAC_W);
        return s >> FRAC_W;
    endfunction

    task automatic model_reset();
        m_n = 0; m_next = 0; m_line = 0; m_frame = 0; m_field = 0;
        m_std = 0; m_frac = 0; m_aud = 0; m_hs = 0; m_at = 0; m_irq = 0;
        first_hs = -1;
    endtask

    task automatic compare_all();
        chk("R2 hsync", int'(hsync), m_hs);
        chk("R3 line", int'(line), m_line);
        chk("R4 irq", int'(virq), m_irq);
        chk("R4 vblank", int'(vbl), (m_line >= VBL) ? 1 : 0);
        chk("R5 frame", int'(frame), m_frame);
        chk("R6 audio", int'(atick), m_at);
        chk("R7 field", int'(field), m_field);
        chk("R8 standard", int'(pact), m_std);
    endtask

    // advance one clock with the reference model, then compare at negedge
    task automatic step();
        @(posedge clk);
        m_n++;
        m_hs = 0; m_at = 0; m_irq = 0;
        if (m_n == 1) begin
            m_std = int'(pal_sel);
            m_next = 1 + next_len(m_std);
        end else if (m_n == m_next) begin
            m_hs = 1;
            m_aud++;
            if (m_aud == AUDL) begin
                m_at = 1;
                m_aud = 0;
            end
            if (m_line == ((m_std != 0) ? PL : NL) - 1) begin
                m_line = 0;
                m_frame = (m_frame + 1) % (1 << FW);
                m_std = int'(pal_sel);
                m_field = ilace ? (m_frame % 2) : 0;
            end else begin
                m_line++;
            end
            m_irq = (m_line == VBL) ? 1 : 0;
            m_next = m_n + next_len(m_std);
        end
        @(negedge clk);
        if (hsync && first_hs < 0) first_hs = m_n;
        compare_all();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            // R1: all outputs idle under reset
            chk("R1 reset outputs", int'({hsync, atick, virq, vbl, field, pact}), 0);
            chk("R1 reset line", int'(line), 0);
            chk("R1 reset frame", int'(frame), 0);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        ilace = 1'b1;
        pal_sel = 1'b0;
        do_reset(3);
        run(1);
        // R1: first cycle after release still shows zeros apart from the latched standard
        chk("R1 post-release line", int'(line), 0);
        run(1200);
        // R2: first line length without carried fraction
        chk("R2 first line", first_hs, 1 + (NSTEP >> FRAC_W));

        // R8: sweep a mid-frame standard change over many offsets
        for (int k = 0; k < 12; k++) begin
            pal_sel = ~pal_sel;
            run(37 + 3 * k);
        end
        pal_sel = 1'b1;
        run(900);

        // R7: interlace off then on again
        ilace = 1'b0;
        run(500);
        ilace = 1'b1;
        pal_sel = 1'b0;
        run(700);

        // R9: reset in the middle of a run, restart with the 50 Hz step
        pal_sel = 1'b1;
        run(23);
        do_reset(2);
        run(1000);
        chk("R9 first line after reset", first_hs, 1 + (PSTEP >> FRAC_W));
        chk("R9 standard after reset", int'(pact), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule